// File: doc/BRIEF.md
# Capture/Compare Timer with Two-Step Flag Clearing

This block is a 16-bit free-running timer that hangs off a simple 8-bit register bus. Around the counter sit one input-capture channel with a selectable edge and one output-compare channel. A counter wrap also counts as an event. The capture, compare and wrap events each raise a sticky flag. The flags are reported together in one read-only status byte, and each flag drives a level interrupt request through its own enable bit.

A flag never clears on a plain write. Software must first access the status byte while the flag is up. It then touches the low byte of the data register that belongs to that flag. A second, side-effect-free view of the counter lets software time intervals without losing a pending wrap flag. In both counter views, a read of the high byte freezes the low byte, so a high/low pair always returns one coherent 16-bit value.

Two low-power inputs shape the behaviour:
- While the wait input is high, the timer keeps running, and any enabled request raises a wake indication.
- While the stop input is high, the counter freezes. The first valid capture edge is parked without raising anything. The parked edge becomes a normal capture when stop is released. A reset during stop throws it away.

Top module: `evt_timer`

## Requirements
- R1: The status byte at address 0x13 reports the capture flag in bit 7, the compare flag in bit 6 and the wrap flag in bit 5. Bits 4..0 always read 0. Writes to it change no flag.
- R2: Reset loads the counter with 0xFFFC. Outside stop, the counter advances by one every clock. The wrap flag is first visible in the cycle in which the counter reads 0x0000.
- R3: The compare value is written high byte first (0x16) and takes effect on the low-byte write (0x17). The compare flag is first visible in the cycle in which the counter reads the compare value plus one.
- R4: The capture pin passes through two synchroniser flops. Control bit 1 picks the edge: 1 selects rising, 0 selects falling. On a selected edge the capture flag and the capture register (0x14 high, 0x15 low) appear three clocks after the pin changes. The captured value is the counter value at the pin change plus 2. An edge of the other polarity captures nothing.
- R5: A flag clears only when two conditions hold. A status access must have happened while that flag was set. After it, a read or write must reach the flag's low byte: 0x15 for capture, 0x17 for compare, 0x19 for wrap. Without the earlier status access, the low-byte access leaves the flag set.
- R6: A flag that rises after the last status access survives the next access to its low byte.
- R7: The alternate counter at 0x1A/0x1B returns the same value as the main counter at 0x18/0x19. Reading it never clears the wrap flag.
- R8: In each counter view, a high-byte read freezes the low byte. The next low-byte read of that view returns the frozen byte.
- R9: Each interrupt request is its flag ANDed with its enable in the control byte at 0x12: bit 7 for capture, bit 6 for compare, bit 5 for wrap. The wake output is high while the wait input is high and any request is high. The counter keeps running in wait.
- R10: While stop is high, the counter holds its value. A capture edge in stop raises neither a flag nor a request. One clock after stop falls, the capture flag and the count held at the first edge during stop appear.
- R11: A reset during stop discards a parked capture: the flag and the capture data read 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational in the strobe cycle |
| cap_in | input | 1 | Asynchronous capture pin |
| stop_mode | input | 1 | Stop request: freeze the counter, park capture edges |
| wait_mode | input | 1 | Wait request: the timer keeps running |
| irq_cap | output | 1 | Capture request level |
| irq_cmp | output | 1 | Compare request level |
| irq_ovf | output | 1 | Wrap request level |
| wait_wake | output | 1 | Wake indication while waiting |

## Verification
Read data is combinational, so the bench samples it shortly after it drives a strobe at the falling edge. The side effects of that read land on the next rising edge.

Each flag result has its own latency:
- The wrap flag is due in the cycle after the counter shows 0xFFFF.
- The compare flag is due one cycle after the counter equals the compare value.
- A capture is due three rising edges after the pin moves.
- A parked capture is due one edge after stop falls.

A bench-side counter model is advanced on the same edges with the same reset and stop inputs. Each check waits until that model reaches the exact count where a result is due. It then reads once just before the result is due and once in the cycle it is due, so a result that comes early or late is reported.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int NFLAG  = 3;
    localparam int NVIEW  = 2;

    localparam logic [CNT_W-1:0] CNT_RESET = 16'hFFFC;

    // flag indices
    localparam int FL_CAP = 0;
    localparam int FL_CMP = 1;
    localparam int FL_OVF = 2;

    // counter views
    localparam int V_MAIN = 0;
    localparam int V_ALT  = 1;

    typedef enum logic [7:0] {
        A_CTRL   = 8'h12,
        A_STAT   = 8'h13,
        A_CAP_HI = 8'h14,
        A_CAP_LO = 8'h15,
        A_CMP_HI = 8'h16,
        A_CMP_LO = 8'h17,
        A_CNT_HI = 8'h18,
        A_CNT_LO = 8'h19,
        A_ALT_HI = 8'h1A,
        A_ALT_LO = 8'h1B
    } reg_addr_e;

    typedef struct packed {
        logic       cap_ie;
        logic       cmp_ie;
        logic       ovf_ie;
        logic [2:0] pad_hi;
        logic       rise;
        logic       pad_lo;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_byte(input logic [BYTE_W-1:0] b);
        ctrl_t c;
        c        = ctrl_t'(b);
        c.pad_hi = '0;
        c.pad_lo = 1'b0;
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(input logic [NFLAG-1:0] f);
        return {f[FL_CAP], f[FL_CMP], f[FL_OVF], 5'b00000};
    endfunction

endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int           W       = 16,
    parameter int           NV      = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic [NV-1:0]           rd_hi,
    input  logic [NV-1:0]           rd_lo,
    output logic [W-1:0]            cnt,
    output logic [NV-1:0][W/2-1:0]  lo_view,
    output logic                    wrap
);
    localparam int           HALF = W / 2;
    localparam logic [W-1:0] ONE  = W'(1);

    always_ff @(posedge clk) begin
        if (rst)      cnt <= RST_VAL;
        else if (run) cnt <= cnt + ONE;
    end

    assign wrap = run && (cnt == '1);

    for (genvar v = 0; v < NV; v++) begin : g_view
        logic [HALF-1:0] frz_q;
        logic            held_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                frz_q  <= '0;
                held_q <= 1'b0;
            end else if (rd_hi[v]) begin
                frz_q  <= cnt[HALF-1:0];
                held_q <= 1'b1;
            end else if (rd_lo[v]) begin
                held_q <= 1'b0;
            end
        end

        assign lo_view[v] = held_q ? frz_q : cnt[HALF-1:0];
    end
endmodule

// File: rtl/evt_capture.sv
module evt_capture #(
    parameter int W    = 16,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pin,
    input  logic         rise_sel,
    input  logic         stop,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cap_val,
    output logic         cap_set
);
    logic [SYNC-1:0] sync_q;
    logic            prev_q;
    logic            stop_q;
    logic            pend_v;
    logic [W-1:0]    pend_val;
    logic            level;
    logic            edge_seen;
    logic            live_hit;
    logic            wake_hit;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC-2:0], pin};
    end

    assign level     = sync_q[SYNC-1];
    assign edge_seen = rise_sel ? (level & ~prev_q) : (~level & prev_q);
    assign live_hit  = edge_seen & ~stop;
    assign wake_hit  = stop_q & ~stop & pend_v;
    assign cap_set   = live_hit | wake_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            stop_q   <= 1'b0;
            pend_v   <= 1'b0;
            pend_val <= '0;
            cap_val  <= '0;
        end else begin
            prev_q <= level;
            stop_q <= stop;
            if (live_hit)      cap_val <= cnt;
            else if (wake_hit) cap_val <= pend_val;
            if (stop) begin
                if (edge_seen && !pend_v) begin
                    pend_v   <= 1'b1;
                    pend_val <= cnt;
                end
            end else begin
                pend_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/evt_flags.sv
module evt_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         stat_acc,
    input  logic [N-1:0] data_acc,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic arm_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                flag[i] <= 1'b0;
                arm_q   <= 1'b0;
            end else begin
                if (set[i])                      flag[i] <= 1'b1;
                else if (arm_q && data_acc[i])   flag[i] <= 1'b0;

                if (data_acc[i])                 arm_q <= 1'b0;
                else if (stat_acc && flag[i])    arm_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [CNT_W-1:0] RESET_COUNT = CNT_RESET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cap_in,
    input  logic              stop_mode,
    input  logic              wait_mode,
    output logic              irq_cap,
    output logic              irq_cmp,
    output logic              irq_ovf,
    output logic              wait_wake
);
    localparam int HALF = CNT_W / 2;

    ctrl_t                        ctrl_q;
    logic [CNT_W-1:0]             cmp_q;
    logic [HALF-1:0]              cmp_hold_q;
    logic [CNT_W-1:0]             cnt_q;
    logic [CNT_W-1:0]             cap_q;
    logic [NVIEW-1:0][HALF-1:0]   lo_view;
    logic [NVIEW-1:0]             rd_hi;
    logic [NVIEW-1:0]             rd_lo;
    logic [NFLAG-1:0]             set_vec;
    logic [NFLAG-1:0]             acc_vec;
    logic [NFLAG-1:0]             flag_q;
    logic                         run;
    logic                         wrap;
    logic                         cap_set;
    logic                         acc;
    logic                         stat_acc;

    assign run      = ~stop_mode;
    assign acc      = bus_rd | bus_wr;
    assign stat_acc = acc && (bus_addr == A_STAT);

    assign rd_hi[V_MAIN] = bus_rd && (bus_addr == A_CNT_HI);
    assign rd_lo[V_MAIN] = bus_rd && (bus_addr == A_CNT_LO);
    assign rd_hi[V_ALT]  = bus_rd && (bus_addr == A_ALT_HI);
    assign rd_lo[V_ALT]  = bus_rd && (bus_addr == A_ALT_LO);

    evt_counter #(.W(CNT_W), .NV(NVIEW), .RST_VAL(RESET_COUNT)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .rd_hi   (rd_hi),
        .rd_lo   (rd_lo),
        .cnt     (cnt_q),
        .lo_view (lo_view),
        .wrap    (wrap)
    );

    evt_capture #(.W(CNT_W), .SYNC(SYNC_STAGES)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .pin      (cap_in),
        .rise_sel (ctrl_q.rise),
        .stop     (stop_mode),
        .cnt      (cnt_q),
        .cap_val  (cap_q),
        .cap_set  (cap_set)
    );

    // compare register: high byte is staged, low-byte write commits
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            cmp_q      <= '0;
            cmp_hold_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL:   ctrl_q     <= ctrl_from_byte(bus_wdata);
                A_CMP_HI: cmp_hold_q <= bus_wdata;
                A_CMP_LO: cmp_q      <= {cmp_hold_q, bus_wdata};
                default:  ;
            endcase
        end
    end

    assign set_vec[FL_CAP] = cap_set;
    assign set_vec[FL_CMP] = run && (cnt_q == cmp_q);
    assign set_vec[FL_OVF] = wrap;

    assign acc_vec[FL_CAP] = acc && (bus_addr == A_CAP_LO);
    assign acc_vec[FL_CMP] = acc && (bus_addr == A_CMP_LO);
    assign acc_vec[FL_OVF] = acc && (bus_addr == A_CNT_LO);

    evt_flags #(.N(NFLAG)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set      (set_vec),
        .stat_acc (stat_acc),
        .data_acc (acc_vec),
        .flag     (flag_q)
    );

    assign irq_cap   = flag_q[FL_CAP] & ctrl_q.cap_ie;
    assign irq_cmp   = flag_q[FL_CMP] & ctrl_q.cmp_ie;
    assign irq_ovf   = flag_q[FL_OVF] & ctrl_q.ovf_ie;
    assign wait_wake = wait_mode & (irq_cap | irq_cmp | irq_ovf);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_CTRL:   bus_rdata = ctrl_q;
                A_STAT:   bus_rdata = status_byte(flag_q);
                A_CAP_HI: bus_rdata = cap_q[CNT_W-1:HALF];
                A_CAP_LO: bus_rdata = cap_q[HALF-1:0];
                A_CMP_HI: bus_rdata = cmp_q[CNT_W-1:HALF];
                A_CMP_LO: bus_rdata = cmp_q[HALF-1:0];
                A_CNT_HI: bus_rdata = cnt_q[CNT_W-1:HALF];
                A_CNT_LO: bus_rdata = lo_view[V_MAIN];
                A_ALT_HI: bus_rdata = cnt_q[CNT_W-1:HALF];
                A_ALT_LO: bus_rdata = lo_view[V_ALT];
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        stop_mode,
    input logic [15:0] count,
    input logic [15:0] cmp,
    input logic [2:0]  flags,
    input logic [7:0]  bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [7:0]  bus_rdata
);
    AST_STAT_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 8'h13) |-> (bus_rdata[4:0] == 5'b0)); // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !stop_mode |=> (count == $past(count) + 16'd1)); // R2

    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!stop_mode && count == 16'hFFFF) |=> flags[2]); // R2

    AST_CMP_MATCH: assert property (@(posedge clk) disable iff (rst)
        (!stop_mode && count == cmp) |=> flags[1]); // R3

    AST_OVF_CLEAR_PATH: assert property (@(posedge clk) disable iff (rst)
        ($fell(flags[2]) && !$past(rst)) |-> $past((bus_rd || bus_wr) && bus_addr == 8'h19)); // R5

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        stop_mode |=> $stable(count)); // R10

    AST_STOP_NO_CAPFLAG: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && !flags[0]) |=> !flags[0]); // R10
endmodule

bind evt_timer evt_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .stop_mode (stop_mode),
    .count     (cnt_q),
    .cmp       (cmp_q),
    .flags     (flag_q),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata)
);

// File: tb/evt_timer_test.sv
`timescale 1ns/1ps
module evt_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cap_in = 1'b0;
    logic       stop_mode = 1'b0;
    logic       wait_mode = 1'b0;
    logic       irq_cap, irq_cmp, irq_ovf, wait_wake;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] model;

    always #2 clk = ~clk;

    evt_timer uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
        .stop_mode(stop_mode), .wait_mode(wait_mode), .irq_cap(irq_cap),
        .irq_cmp(irq_cmp), .irq_ovf(irq_ovf), .wait_wake(wait_wake)
    );

    // counter expectation from the reset value and run rules
    always @(posedge clk) begin
        if (rst)             model <= 16'hFFFC;
        else if (!stop_mode) model <= model + 16'd1;
    end

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_model(input logic [15:0] v);
        while (model != v) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] m, v;
        idle(3);
        // reset state
        rd(8'h1B, d); check("R2", "reset count low", {8'h0, d}, 16'h00FC);
        rd(8'h13, d); check("R1", "reset status", {8'h0, d}, 16'h0000);
        rst = 1'b0;

        // wrap and compare(=0) flags after reset
        wait_model(16'h0003);
        rd(8'h13, d); check("R2", "wrap+cmp flags", {8'h0, d}, 16'h0060);

        // alternate view, coherent
        m = model;
        rd(8'h1A, d); check("R7", "alt high", {8'h0, d}, {8'h0, m[15:8]});
        rd(8'h1B, d); check("R8", "alt low frozen", {8'h0, d}, {8'h0, m[7:0]});
        rd(8'h13, d); check("R7", "alt keeps wrap flag", {8'h0, d}, 16'h0060);

        // main view coherent; low read completes wrap clear
        m = model;
        rd(8'h18, d); check("R8", "main high", {8'h0, d}, {8'h0, m[15:8]});
        rd(8'h19, d); check("R8", "main low frozen", {8'h0, d}, {8'h0, m[7:0]});
        rd(8'h13, d); check("R5", "wrap cleared", {8'h0, d}, 16'h0040);
        rd(8'h17, d);
        rd(8'h13, d); check("R5", "compare cleared", {8'h0, d}, 16'h0000);

        // status writes change nothing
        wr(8'h13, 8'hFF);
        rd(8'h13, d); check("R1", "status write ignored", {8'h0, d}, 16'h0000);

        // compare timing
        v = model + 16'd40;
        wr(8'h16, v[15:8]); wr(8'h17, v[7:0]);
        wait_model(v);
        rd(8'h13, d); check("R3", "compare not yet", {8'h0, d}, 16'h0000);
        rd(8'h13, d); check("R3", "compare due", {8'h0, d}, 16'h0040);
        rd(8'h17, d);
        rd(8'h13, d); check("R5", "compare cleared again", {8'h0, d}, 16'h0000);

        // no clear without a status access first
        v = model + 16'd30;
        wr(8'h16, v[15:8]); wr(8'h17, v[7:0]);
        wait_model(v + 16'd2);
        rd(8'h17, d);
        rd(8'h13, d); check("R5", "unarmed access keeps flag", {8'h0, d}, 16'h0040);
        rd(8'h17, d);
        rd(8'h13, d); check("R5", "armed access clears", {8'h0, d}, 16'h0000);

        // flag rising after the status access survives
        v = model + 16'd20;
        wr(8'h16, v[15:8]); wr(8'h17, v[7:0]);
        rd(8'h13, d); check("R6", "status before set", {8'h0, d}, 16'h0000);
        wait_model(v + 16'd2);
        rd(8'h17, d);
        rd(8'h13, d); check("R6", "late flag survives", {8'h0, d}, 16'h0040);
        rd(8'h17, d);
        rd(8'h13, d);

        // capture sweep: polarity x edge direction
        for (int pol = 0; pol < 2; pol++) begin
            wr(8'h12, pol[0] ? 8'h02 : 8'h00);
            for (int dir = 0; dir < 2; dir++) begin
                cap_in = ~dir[0];
                idle(6);
                rd(8'h13, d); rd(8'h15, d);
                cap_in = dir[0];
                m = model;
                idle(3);
                rd(8'h13, d);
                check("R4", $sformatf("capture flag pol=%0d dir=%0d", pol, dir),
                      {15'h0, d[7]}, {15'h0, pol == dir});
                if (pol == dir) begin
                    v = m + 16'd2;
                    rd(8'h14, d); check("R4", "capture high", {8'h0, d}, {8'h0, v[15:8]});
                    rd(8'h15, d); check("R4", "capture low", {8'h0, d}, {8'h0, v[7:0]});
                    rd(8'h13, d); check("R5", "capture cleared", {15'h0, d[7]}, 16'h0000);
                end
            end
        end

        // interrupt requests and wait
        wr(8'h12, 8'h82);
        cap_in = 1'b0; idle(5);
        rd(8'h13, d); rd(8'h15, d);
        cap_in = 1'b1; idle(3);
        check("R9", "irq_cap enabled", {15'h0, irq_cap}, 16'h0001);
        check("R9", "irq_cmp disabled", {15'h0, irq_cmp}, 16'h0000);
        wait_mode = 1'b1; idle(1);
        check("R9", "wake in wait", {15'h0, wait_wake}, 16'h0001);
        m = model;
        rd(8'h1A, d); rd(8'h1B, d);
        check("R9", "count runs in wait", {8'h0, d}, {8'h0, m[7:0]});
        check("R9", "count moved in wait", model, m + 16'd2);
        wr(8'h12, 8'h02);
        check("R9", "irq_cap masked", {15'h0, irq_cap}, 16'h0000);
        check("R9", "wake masked", {15'h0, wait_wake}, 16'h0000);
        wait_mode = 1'b0;
        rd(8'h13, d); rd(8'h15, d);

        // stop: hold, park first edge, release
        wr(8'h12, 8'h82);
        cap_in = 1'b0; idle(4);
        stop_mode = 1'b1; idle(1);
        m = model;
        rd(8'h1A, d); check("R10", "held high", {8'h0, d}, {8'h0, m[15:8]});
        rd(8'h1B, d); check("R10", "held low", {8'h0, d}, {8'h0, m[7:0]});
        idle(5);
        rd(8'h1B, d); check("R10", "still held", {8'h0, d}, {8'h0, m[7:0]});
        cap_in = 1'b1; idle(6);
        rd(8'h13, d); check("R10", "no flag in stop", {15'h0, d[7]}, 16'h0000);
        check("R10", "no irq in stop", {15'h0, irq_cap}, 16'h0000);
        cap_in = 1'b0; idle(3); cap_in = 1'b1; idle(4);
        stop_mode = 1'b0; idle(1);
        rd(8'h13, d); check("R10", "flag after stop", {15'h0, d[7]}, 16'h0001);
        check("R10", "irq after stop", {15'h0, irq_cap}, 16'h0001);
        rd(8'h14, d); check("R10", "parked high", {8'h0, d}, {8'h0, m[15:8]});
        rd(8'h15, d); check("R10", "parked low", {8'h0, d}, {8'h0, m[7:0]});

        // reset during stop discards
        cap_in = 1'b0; idle(4);
        stop_mode = 1'b1; idle(2);
        cap_in = 1'b1; idle(6);
        rst = 1'b1; idle(1);
        stop_mode = 1'b0; rst = 1'b0;
        rd(8'h13, d); check("R11", "no flag after reset", {8'h0, d}, 16'h0000);
        rd(8'h14, d); check("R11", "capture high cleared", {8'h0, d}, 16'h0000);
        rd(8'h15, d); check("R11", "capture low cleared", {8'h0, d}, 16'h0000);

        // exact wrap timing
        wait_model(16'h0005);
        rd(8'h13, d); check("R2", "flags after second reset", {8'h0, d}, 16'h0060);
        rd(8'h19, d); rd(8'h17, d);
        wait_model(16'hFFFF);
        rd(8'h13, d); check("R2", "wrap not yet", {15'h0, d[5]}, 16'h0000);
        rd(8'h13, d); check("R2", "wrap due", {15'h0, d[5]}, 16'h0001);
        check("R1", "status pad bits", {11'h0, d[4:0]}, 16'h0000);

        summary();
        $finish;
    end
endmodule